// File: doc/BRIEF.md
# Three-Line GPIO Port with Direction Readback

This block is a small general-purpose I/O port with three lines, reached through a byte-wide register port. A single address selects one of three registers. The direction register decides, line by line, whether the block drives the line or only listens to it. The output register holds the level to drive. The input register reports what is seen on the lines.

External levels enter through a two-flop synchronizer and are sampled all the time. Input changes never raise any event. When a line is an output, its input read shows the block's own driven level ORed with the synchronized external level. Each line also has a single-cycle change strobe. The strobe pulses whenever a register write alters the line's driven state, meaning either its output enable or the level it drives.

The direction register also holds two configuration bits that belong to no line. They are stored and read back, and they have no other effect.

Top module: `gpio3_port`

## Requirements
- R1: After reset the direction register reads 0x07 (all lines inputs), the output register reads 0x00, every output enable and output pin is low, and no strobe is raised.
- R2: A write to the direction register (address 0) stores only the bits of mask 0x67. Bits 2:0 select line direction, with 1 meaning input. Bits 6:5 are storage only. Bits 7, 4 and 3 read back as 0.
- R3: A write to the output register (address 1) stores only bits 2:0, and bits 7:3 read back as 0.
- R4: A read of the input register (address 2) returns, for each line, its synchronized external level ORed with its output-register bit when the line's direction bit is 0. Bits 7:3 read as 0.
- R5: A change of an external input level becomes visible in the input register after the second rising clock edge following the change, and not earlier.
- R6: A line whose direction bit is 1 has its output enable low and its output pin low. A line whose direction bit is 0 has its output enable high and its output pin equal to its output-register bit.
- R7: Any write that flips a line's direction bit raises that line's strobe for exactly the one cycle after the write edge, even if the pin level stays the same.
- R8: A write to the output register raises a line's strobe for one cycle only if that line is an output and its bit changes. Rewriting the same value, or changing the bit of an input line, raises no strobe.
- R9: Writes to the input register address (2) and to the unused address 3 change no register and no pin. Address 3 reads as 0x00.
- R10: Changes of the external input levels never raise a strobe and never alter the output enables or output pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register, combinational |
| pin_in | input | 3 | External line levels, asynchronous |
| pin_out | output | 3 | Driven line levels |
| pin_oe | output | 3 | Per-line output enable |
| strobe | output | 3 | Per-line driven-state change pulse |

## Verification
The assertions assume that register writes are the only thing that can move the output enables, output pins and strobes. They therefore require wr_en to be low throughout reset. They also assume that wr_en, addr and wr_data are stable across each rising edge. The stimulus meets these assumptions by driving all inputs one time unit after a rising edge and holding wr_en low during reset. External levels are changed at arbitrary points relative to the clock, and the synchronizer absorbs them.

// File: rtl/gpio3_port.sv
module gpio3_port #(
  parameter int          LINES    = 3,
  parameter int          DW       = 8,
  parameter int          AW       = 2,
  parameter logic [7:0]  DIR_KEEP = 8'h67,
  parameter logic [7:0]  DIR_INIT = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] pin_out,
  output logic [LINES-1:0] pin_oe,
  output logic [LINES-1:0] strobe
);
  localparam logic [AW-1:0] A_DIR = AW'(0);
  localparam logic [AW-1:0] A_OUT = AW'(1);
  localparam logic [AW-1:0] A_IN  = AW'(2);
  localparam logic [LINES-1:0] OE_INIT = ~DIR_INIT[LINES-1:0];

  logic [DW-1:0]    dir_q;
  logic [LINES-1:0] out_q, meta_q, sync_q, last_oe_q, last_lvl_q;

  assign pin_oe  = ~dir_q[LINES-1:0];
  assign pin_out = out_q & pin_oe;
  assign strobe  = (pin_oe ^ last_oe_q) | (pin_out ^ last_lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q      <= DIR_INIT & DIR_KEEP;
      out_q      <= '0;
      meta_q     <= '0;
      sync_q     <= '0;
      last_oe_q  <= OE_INIT;
      last_lvl_q <= '0;
    end else begin
      meta_q     <= pin_in;
      sync_q     <= meta_q;
      last_oe_q  <= pin_oe;
      last_lvl_q <= pin_out;
      if (wr_en) begin
        case (addr)
          A_DIR:   dir_q <= wr_data & DIR_KEEP;
          A_OUT:   out_q <= wr_data[LINES-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rd_data = dir_q;
      A_OUT:   rd_data = DW'(out_q);
      A_IN:    rd_data = DW'(sync_q | (out_q & pin_oe));
      default: rd_data = '0;
    endcase
  end
endmodule

module gpio3_port_chk #(
  parameter int LINES = 3,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic [DW-1:0]    wr_data,
  input logic [LINES-1:0] pin_out,
  input logic [LINES-1:0] pin_oe,
  input logic [LINES-1:0] strobe
);
  // R6
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R7
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> strobe == '0);

  // R10
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(pin_oe) && $stable(pin_out)));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> pin_oe == ~$past(wr_data[LINES-1:0]));

  // R8
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> pin_out == ($past(wr_data[LINES-1:0]) & pin_oe));

  // R8
  same_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && (wr_data[LINES-1:0] & pin_oe) == pin_out) |=> strobe == '0);
endmodule

bind gpio3_port gpio3_port_chk #(.LINES(LINES), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .pin_out(pin_out), .pin_oe(pin_oe), .strobe(strobe)
);

// File: tb/test_gpio3_port.sv
module test_gpio3_port;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_OE = 1, K_PIN = 2, K_STB = 3;

  typedef struct {
    int        kind;
    logic [7:0] exp;
    string     tag;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] addr = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] pin_in = '0;
  logic [2:0] pin_out, pin_oe, strobe;

  item_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  gpio3_port i_gpio3_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .strobe(strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = rd_data;
        K_OE:    act = {5'b0, pin_oe};
        K_PIN:   act = {5'b0, pin_out};
        default: act = {5'b0, strobe};
      endcase
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic expect_rd(logic [1:0] a, logic [7:0] exp, string tag);
    addr = a;
    expect_item(K_RD, exp, tag);
    @(posedge clk); #1;
  endtask

  task automatic write_reg(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_item(K_STB, 8'h00, "R1 strobe");
    expect_item(K_OE,  8'h00, "R1 oe");
    expect_item(K_PIN, 8'h00, "R1 pins");
    expect_rd(2'd0, 8'h07, "R1 dir");
    expect_rd(2'd1, 8'h00, "R1 out");

    // R2 mask, line bits unchanged so no strobe
    write_reg(2'd0, 8'hFF);
    expect_item(K_STB, 8'h00, "R7 no flip no strobe");
    expect_rd(2'd0, 8'h67, "R2 dir mask");

    // all outputs
    write_reg(2'd0, 8'h98);
    expect_item(K_STB, 8'h07, "R7 dir flip strobe");
    expect_item(K_STB, 8'h00, "R7 strobe one cycle");
    expect_rd(2'd0, 8'h00, "R2 dir clears");
    expect_item(K_OE,  8'h07, "R6 oe outputs");
    expect_item(K_PIN, 8'h00, "R6 pins low");

    // R3 / R8
    write_reg(2'd1, 8'hFD);
    expect_item(K_STB, 8'h05, "R8 level strobe");
    expect_item(K_PIN, 8'h05, "R6 pin follows out");
    expect_rd(2'd1, 8'h05, "R3 out mask");
    write_reg(2'd1, 8'h05);
    expect_item(K_STB, 8'h00, "R8 same value quiet");

    // R4 merge
    expect_rd(2'd2, 8'h05, "R4 own outputs");
    pin_in = 3'b010;
    expect_item(K_STB, 8'h00, "R10 input no strobe");
    repeat (3) @(posedge clk); #1;
    expect_rd(2'd2, 8'h07, "R4 merged");

    // back to inputs
    write_reg(2'd0, 8'h07);
    expect_item(K_STB, 8'h07, "R7 to inputs");
    expect_item(K_OE,  8'h00, "R6 oe off");
    expect_item(K_PIN, 8'h00, "R6 pins held low");
    expect_rd(2'd2, 8'h02, "R4 outputs masked");

    // R5 latency
    @(posedge clk); #1;
    pin_in = 3'b100;
    addr = 2'd2;
    expect_item(K_RD, 8'h02, "R5 before edges");
    @(posedge clk); #1;
    expect_item(K_RD, 8'h02, "R5 after one edge");
    expect_item(K_STB, 8'h00, "R10 no strobe");
    @(posedge clk); #1;
    expect_item(K_RD, 8'h04, "R5 after two edges");
    expect_item(K_PIN, 8'h00, "R10 pins unchanged");

    // R8 input line change
    write_reg(2'd1, 8'h02);
    expect_item(K_STB, 8'h00, "R8 input line quiet");
    expect_item(K_PIN, 8'h00, "R8 pins low");
    expect_rd(2'd1, 8'h02, "R3 out stored");

    // R9 ignored addresses
    write_reg(2'd2, 8'hFF);
    expect_item(K_STB, 8'h00, "R9 no strobe");
    write_reg(2'd3, 8'h00);
    expect_item(K_OE, 8'h00, "R9 oe");
    expect_rd(2'd0, 8'h07, "R9 dir kept");
    expect_rd(2'd1, 8'h02, "R9 out kept");
    expect_rd(2'd3, 8'h00, "R9 unused reads zero");

    // R7 line 0 to output with level 0
    write_reg(2'd0, 8'h66);
    expect_item(K_STB, 8'h01, "R7 enable only");
    expect_item(K_OE,  8'h01, "R6 line0 out");
    expect_item(K_PIN, 8'h00, "R6 line0 low");
    expect_rd(2'd0, 8'h66, "R2 storage bits");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule